// File: doc/BRIEF.md
# Four-Slot Decode Steering with Pair Fusion

This block sits between instruction fetch and the decoders. Each cycle it sees a window of pre-decoded instruction descriptors and hands them, in program order, to four decode slots. Each descriptor carries a micro-op count and two fusion flags. Slot 0 is the only slot able to take an instruction that expands into several micro-ops. Slots 1 to 3 take only single-micro-op instructions. Two adjacent single-micro-op instructions can be merged into one micro-op, for example a compare that feeds a conditional branch. That merge lets the four slots retire five instructions from the window in one cycle.

An instruction that expands into more micro-ops than slot 0 can produce goes to a microcode sequencer. When it reaches the head of the window, the block raises a request and consumes only that one instruction. It then lowers its ready output until the sequencer signals completion. The fetch side advances its window by the consumed count on every cycle in which the window is valid and the block is ready.

The slot outputs and the consumed count are combinational functions of the presented window. The only state is the flag that records a pending wait for the sequencer.

Top module: `decode_steer`

## Requirements
- R1: Slot 0 accepts an instruction whose micro-op count is 1 to 4. Slots 1, 2 and 3 accept only a count of 1, and a count field of 0 counts as 1. Each slot reports its count on `slot_uops` (4 bits per slot, slot s at bits [4s+3:4s]). A fused slot reports 1.
- R2: An instruction with a count of 2 to 4 that is not at window position 0 is not placed. It and every later instruction stay unconsumed in that cycle.
- R3: An instruction with a count above 4 at window position 0 causes the following in the same cycle: `msq_req` is 1, `msq_uops` equals its count, `consumed` is 1, and no slot is valid. The same instruction at any later position stops assignment there without a request.
- R4: After an accepted request, `win_ready` is 0 from the next cycle onward. It returns to 1 in the cycle after the one in which `msq_done` is sampled high. `msq_done` has no effect while no request is pending.
- R5: Two instructions at positions i and i+1 are fused into one slot when all of the following hold: both are inside the window, both have a count of 1, position i has `win_fuse_first` set, and position i+1 has `win_fuse_second` set. The fused slot shows `slot_fused` set and `slot_pos` equal to i, and it adds 2 to `consumed`.
- R6: At most one pair is fused per cycle. A later eligible pair is decoded as separate instructions, so `consumed` never exceeds 5.
- R7: A single-micro-op instruction with `win_fuse_first` set at the last valid window position is held. Assignment stops in front of it.
- R8: Instructions are assigned in program order to slots 0, 1, 2, 3. Valid slots are contiguous from slot 0, and `slot_pos` (3 bits per slot) gives each slot's window position. Assignment stops at the first instruction that cannot take the next free slot.
- R9: When `win_valid` or `win_ready` is 0, all slot outputs, `consumed` and `msq_req` are 0.
- R10: After reset, `win_ready` is 1 and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_valid | input | 1 | Window holds valid descriptors |
| win_ready | output | 1 | Block can accept the window this cycle |
| win_count | input | 3 | Number of valid positions in the window |
| win_uops | input | 24 | Micro-op count per position, 4 bits each |
| win_fuse_first | input | 6 | Position can lead a fused pair |
| win_fuse_second | input | 6 | Position can close a fused pair |
| slot_valid | output | 4 | Slot holds an instruction |
| slot_fused | output | 4 | Slot holds a fused pair |
| slot_pos | output | 12 | Window position per slot, 3 bits each |
| slot_uops | output | 16 | Micro-op count per slot, 4 bits each |
| consumed | output | 3 | Instructions taken from the window this cycle |
| msq_req | output | 1 | Hand the head instruction to the sequencer |
| msq_uops | output | 4 | Micro-op count of the handed-off instruction |
| msq_done | input | 1 | Sequencer has finished the handed-off instruction |

## Verification
Slot assignment, fusion, the consumed count and the sequencer request all depend only on the window presented in the current cycle. The bench drives each window on a falling edge and samples these outputs shortly afterwards, before the next rising edge. The ready output is the only registered result. It falls one rising edge after an accepted request and rises one edge after `msq_done` is taken. The bench therefore checks ready on the falling edge that follows each of those rising edges. It also checks that ready is still low while `msq_done` is being held, before that edge arrives.

// File: rtl/dm_pkg.sv
package dm_pkg;
  localparam int NSLOT    = 4;  // decode slots, slot 0 is the complex one
  localparam int CPLX_MAX = 4;  // largest micro-op count slot 0 expands

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_WAIT = 1'b1
  } sq_state_e;
endpackage

// File: rtl/dm_pos_class.sv
// Classifies one window position and its pairing with the next position.
module dm_pos_class
  import dm_pkg::*;
#(
  parameter int UOPW = 4
) (
  input  logic [UOPW-1:0] uops,
  input  logic            in_win,
  input  logic            lead_ok,
  input  logic [UOPW-1:0] nxt_uops,
  input  logic            nxt_in_win,
  input  logic            nxt_close_ok,
  output logic            is_single,
  output logic            is_multi,
  output logic            is_long,
  output logic            can_pair,
  output logic            must_hold
);
  localparam logic [UOPW-1:0] ONE  = UOPW'(1);
  localparam logic [UOPW-1:0] CMAX = UOPW'(CPLX_MAX);

  logic nxt_single;

  always_comb begin
    is_single  = in_win && (uops <= ONE);
    is_multi   = in_win && (uops > ONE) && (uops <= CMAX);
    is_long    = in_win && (uops > CMAX);
    nxt_single = nxt_in_win && (nxt_uops <= ONE);
    can_pair   = is_single && lead_ok && nxt_single && nxt_close_ok;
    must_hold  = is_single && lead_ok && !nxt_in_win;
  end
endmodule

// File: rtl/dm_steer_core.sv
// In-order walk over the window, filling slots and fusing at most one pair.
module dm_steer_core
  import dm_pkg::*;
#(
  parameter int WIN  = 6,
  parameter int UOPW = 4,
  parameter int PW   = 3,
  parameter int CW   = 3
) (
  input  logic [WIN-1:0]        is_single,
  input  logic [WIN-1:0]        is_multi,
  input  logic [WIN-1:0]        is_long,
  input  logic [WIN-1:0]        can_pair,
  input  logic [WIN-1:0]        must_hold,
  input  logic [WIN*UOPW-1:0]   uops_flat,
  output logic [NSLOT-1:0]      sv,
  output logic [NSLOT-1:0]      sf,
  output logic [NSLOT*PW-1:0]   spos_flat,
  output logic [NSLOT*UOPW-1:0] su_flat,
  output logic [CW-1:0]         cons,
  output logic                  seq_req
);
  logic [UOPW-1:0] ua   [WIN];
  logic [PW-1:0]   pa   [NSLOT];
  logic [UOPW-1:0] uo   [NSLOT];
  logic [2:0]      s3;
  logic            stop_w, skip_w, fused_w;

  for (genvar g = 0; g < WIN; g++) begin : g_unpack
    assign ua[g] = uops_flat[g*UOPW +: UOPW];
  end
  for (genvar k = 0; k < NSLOT; k++) begin : g_pack
    assign spos_flat[k*PW +: PW]   = pa[k];
    assign su_flat[k*UOPW +: UOPW] = uo[k];
  end

  always_comb begin
    sv      = '0;
    sf      = '0;
    cons    = '0;
    seq_req = 1'b0;
    s3      = 3'd0;
    stop_w  = 1'b0;
    skip_w  = 1'b0;
    fused_w = 1'b0;
    for (int k = 0; k < NSLOT; k++) begin
      pa[k] = '0;
      uo[k] = '0;
    end
    for (int i = 0; i < WIN; i++) begin
      if (skip_w) begin
        skip_w = 1'b0;
      end else if (!stop_w) begin
        if (is_long[i]) begin
          if (i == 0) begin
            seq_req = 1'b1;
            cons    = CW'(1);
          end
          stop_w = 1'b1;
        end else if (is_multi[i]) begin
          if (s3 == 3'd0) begin
            sv[0] = 1'b1;
            pa[0] = PW'(i);
            uo[0] = ua[i];
            s3    = 3'd1;
            cons  = cons + CW'(1);
          end else begin
            stop_w = 1'b1;
          end
        end else if (is_single[i]) begin
          if (s3 >= 3'(NSLOT)) begin
            stop_w = 1'b1;
          end else if (can_pair[i] && !fused_w) begin
            sv[s3[1:0]] = 1'b1;
            sf[s3[1:0]] = 1'b1;
            pa[s3[1:0]] = PW'(i);
            uo[s3[1:0]] = UOPW'(1);
            s3          = s3 + 3'd1;
            cons        = cons + CW'(2);
            skip_w      = 1'b1;
            fused_w     = 1'b1;
          end else if (must_hold[i]) begin
            stop_w = 1'b1;
          end else begin
            sv[s3[1:0]] = 1'b1;
            pa[s3[1:0]] = PW'(i);
            uo[s3[1:0]] = UOPW'(1);
            s3          = s3 + 3'd1;
            cons        = cons + CW'(1);
          end
        end else begin
          stop_w = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dm_seq_wait.sv
// Holds the block off while the microcode sequencer works.
module dm_seq_wait
  import dm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done,
  output logic busy
);
  sq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      SQ_IDLE: if (start) st_d = SQ_WAIT;
      SQ_WAIT: if (done)  st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign busy = (st_q == SQ_WAIT);

  // R4: a completion seen while waiting releases the block on the next edge
  p_done_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done) |=> !busy);
  // R4: without a start the idle state is kept, whatever done does
  p_idle_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
endmodule

// File: rtl/decode_steer.sv
module decode_steer
  import dm_pkg::*;
#(
  parameter int WIN  = 6,
  parameter int UOPW = 4,
  localparam int PW  = $clog2(WIN),
  localparam int CW  = $clog2(WIN + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  win_valid,
  output logic                  win_ready,
  input  logic [CW-1:0]         win_count,
  input  logic [WIN*UOPW-1:0]   win_uops,
  input  logic [WIN-1:0]        win_fuse_first,
  input  logic [WIN-1:0]        win_fuse_second,
  output logic [NSLOT-1:0]      slot_valid,
  output logic [NSLOT-1:0]      slot_fused,
  output logic [NSLOT*PW-1:0]   slot_pos,
  output logic [NSLOT*UOPW-1:0] slot_uops,
  output logic [CW-1:0]         consumed,
  output logic                  msq_req,
  output logic [UOPW-1:0]       msq_uops,
  input  logic                  msq_done
);
  logic [WIN-1:0] in_win, c_single, c_multi, c_long, c_pair, c_hold;
  logic [NSLOT-1:0]      k_sv, k_sf;
  logic [NSLOT*PW-1:0]   k_pos;
  logic [NSLOT*UOPW-1:0] k_u;
  logic [CW-1:0]         k_cons;
  logic                  k_req, fire, busy;

  for (genvar g = 0; g < WIN; g++) begin : g_pos
    assign in_win[g] = (CW'(g) < win_count);
    if (g < WIN - 1) begin : g_mid
      dm_pos_class #(.UOPW(UOPW)) u_cls (
        .uops        (win_uops[g*UOPW +: UOPW]),
        .in_win      (in_win[g]),
        .lead_ok     (win_fuse_first[g]),
        .nxt_uops    (win_uops[(g+1)*UOPW +: UOPW]),
        .nxt_in_win  (in_win[g+1]),
        .nxt_close_ok(win_fuse_second[g+1]),
        .is_single   (c_single[g]),
        .is_multi    (c_multi[g]),
        .is_long     (c_long[g]),
        .can_pair    (c_pair[g]),
        .must_hold   (c_hold[g])
      );
    end else begin : g_last
      dm_pos_class #(.UOPW(UOPW)) u_cls (
        .uops        (win_uops[g*UOPW +: UOPW]),
        .in_win      (in_win[g]),
        .lead_ok     (win_fuse_first[g]),
        .nxt_uops    ('0),
        .nxt_in_win  (1'b0),
        .nxt_close_ok(1'b0),
        .is_single   (c_single[g]),
        .is_multi    (c_multi[g]),
        .is_long     (c_long[g]),
        .can_pair    (c_pair[g]),
        .must_hold   (c_hold[g])
      );
    end
  end

  dm_steer_core #(.WIN(WIN), .UOPW(UOPW), .PW(PW), .CW(CW)) u_core (
    .is_single(c_single),
    .is_multi (c_multi),
    .is_long  (c_long),
    .can_pair (c_pair),
    .must_hold(c_hold),
    .uops_flat(win_uops),
    .sv       (k_sv),
    .sf       (k_sf),
    .spos_flat(k_pos),
    .su_flat  (k_u),
    .cons     (k_cons),
    .seq_req  (k_req)
  );

  assign win_ready = !busy;
  assign fire      = win_valid && win_ready;

  dm_seq_wait u_wait (
    .clk  (clk),
    .rst_n(rst_n),
    .start(fire && k_req),
    .done (msq_done),
    .busy (busy)
  );

  always_comb begin
    slot_valid = fire ? k_sv   : '0;
    slot_fused = fire ? k_sf   : '0;
    slot_pos   = fire ? k_pos  : '0;
    slot_uops  = fire ? k_u    : '0;
    consumed   = fire ? k_cons : '0;
    msq_req    = fire && k_req;
    msq_uops   = msq_req ? win_uops[UOPW-1:0] : '0;
  end

  // R6: never more than one fused slot, never more than five taken
  p_one_fuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_fused) && (int'(consumed) <= NSLOT + 1));
  // R5: a fused slot is a valid slot
  p_fuse_in_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_fused & ~slot_valid) == '0);
  // R5: taken count equals slots plus one per fused pair
  p_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !msq_req |-> (int'(consumed) == $countones(slot_valid) + $countones(slot_fused)));
  // R8: valid slots form a run starting at slot 0
  p_contig_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid & (slot_valid + NSLOT'(1))) == '0);
  // R3: a handoff takes exactly the head and fills no slot
  p_handoff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    msq_req |-> (consumed == CW'(1)) && (slot_valid == '0));
  // R4: a handoff blocks the next cycle
  p_block_after_r4: assert property (@(posedge clk) disable iff (!rst_n)
    msq_req |=> !win_ready);
  // R9: no transfer, no output
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_valid && win_ready) |-> (consumed == '0) && (slot_valid == '0) && !msq_req);
  // R1: the simple slots carry one micro-op each
  for (genvar s = 1; s < NSLOT; s++) begin : g_simple_chk
    p_simple_r1: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid[s] |-> (slot_uops[s*UOPW +: UOPW] == UOPW'(1)));
  end
endmodule

// File: tb/sim_decode_steer.sv
module sim_decode_steer;
  localparam int WIN = 6, UOPW = 4, PW = 3, CW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic win_valid, win_ready, msq_req, msq_done;
  logic [CW-1:0] win_count, consumed;
  logic [WIN*UOPW-1:0] win_uops;
  logic [WIN-1:0] win_fuse_first, win_fuse_second;
  logic [3:0] slot_valid, slot_fused;
  logic [4*PW-1:0] slot_pos;
  logic [4*UOPW-1:0] slot_uops;
  logic [UOPW-1:0] msq_uops;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  decode_steer u0 (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_ready(win_ready),
    .win_count(win_count), .win_uops(win_uops), .win_fuse_first(win_fuse_first),
    .win_fuse_second(win_fuse_second), .slot_valid(slot_valid), .slot_fused(slot_fused),
    .slot_pos(slot_pos), .slot_uops(slot_uops), .consumed(consumed),
    .msq_req(msq_req), .msq_uops(msq_uops), .msq_done(msq_done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // all positions simple, no fusion flags, full window
  task automatic plain_win();
    for (int i = 0; i < WIN; i++) win_uops[i*UOPW +: UOPW] = 4'd1;
    win_fuse_first  = '0;
    win_fuse_second = '0;
    win_count       = CW'(WIN);
  endtask

  task automatic present();
    @(negedge clk);
    win_valid = 1'b1;
    #2;
  endtask

  task automatic idle();
    win_valid = 1'b0;
    @(negedge clk);
  endtask

  function automatic int pos_of(int s);
    return int'(slot_pos[s*PW +: PW]);
  endfunction

  task automatic t_reset();
    chk("R10", "ready after reset", int'(win_ready), 1);
    chk("R9", "consumed idle", int'(consumed), 0);
    chk("R9", "slots idle", int'(slot_valid), 0);
  endtask

  task automatic t_all_simple();
    plain_win();
    present();
    chk("R8", "valid", int'(slot_valid), 15);
    chk("R8", "consumed", int'(consumed), 4);
    chk("R8", "pos slot3", pos_of(3), 3);
    chk("R6", "no fuse", int'(slot_fused), 0);
    idle();
  endtask

  task automatic t_complex_head();
    plain_win();
    win_uops[3:0] = 4'd3;
    present();
    chk("R1", "valid", int'(slot_valid), 15);
    chk("R1", "slot0 uops", int'(slot_uops[3:0]), 3);
    chk("R1", "consumed", int'(consumed), 4);
    win_uops[3:0] = 4'd4;
    #1;
    chk("R1", "slot0 uops four", int'(slot_uops[3:0]), 4);
    chk("R3", "no req at four", int'(msq_req), 0);
    idle();
  endtask

  task automatic t_complex_late();
    plain_win();
    win_uops[7:4] = 4'd2;
    present();
    chk("R2", "valid", int'(slot_valid), 1);
    chk("R2", "consumed", int'(consumed), 1);
    idle();
  endtask

  task automatic t_fuse_one();
    plain_win();
    win_fuse_first[1]  = 1'b1;
    win_fuse_second[2] = 1'b1;
    present();
    chk("R5", "consumed five", int'(consumed), 5);
    chk("R5", "fused slot1", int'(slot_fused), 2);
    chk("R5", "pos slot1", pos_of(1), 1);
    chk("R5", "pos slot2", pos_of(2), 3);
    chk("R5", "pos slot3", pos_of(3), 4);
    idle();
  endtask

  task automatic t_fuse_two_pairs();
    plain_win();
    win_fuse_first  = 6'b000101;
    win_fuse_second = 6'b001010;
    present();
    chk("R6", "fused only slot0", int'(slot_fused), 1);
    chk("R6", "consumed", int'(consumed), 5);
    chk("R6", "pos slot1", pos_of(1), 2);
    idle();
  endtask

  task automatic t_hold_last();
    plain_win();
    win_count = 3'd3;
    win_fuse_first[2] = 1'b1;
    present();
    chk("R7", "valid", int'(slot_valid), 3);
    chk("R7", "consumed", int'(consumed), 2);
    idle();
  endtask

  task automatic t_pair_multi_partner();
    plain_win();
    win_fuse_first[0]  = 1'b1;
    win_fuse_second[1] = 1'b1;
    win_uops[7:4]      = 4'd2;
    present();
    chk("R5", "no fuse with multi", int'(slot_fused), 0);
    chk("R2", "consumed", int'(consumed), 1);
    idle();
  endtask

  task automatic t_long_late();
    plain_win();
    win_uops[11:8] = 4'd7;
    present();
    chk("R3", "valid", int'(slot_valid), 3);
    chk("R3", "consumed", int'(consumed), 2);
    chk("R3", "no req", int'(msq_req), 0);
    idle();
  endtask

  task automatic t_long_head();
    plain_win();
    win_uops[3:0] = 4'd6;
    present();
    chk("R3", "req", int'(msq_req), 1);
    chk("R3", "req uops", int'(msq_uops), 6);
    chk("R3", "consumed", int'(consumed), 1);
    chk("R3", "no slots", int'(slot_valid), 0);
    @(negedge clk); #2;
    chk("R4", "blocked", int'(win_ready), 0);
    chk("R9", "consumed blocked", int'(consumed), 0);
    chk("R9", "no req blocked", int'(msq_req), 0);
    repeat (2) @(negedge clk);
    #2;
    chk("R4", "still blocked", int'(win_ready), 0);
    @(negedge clk);
    msq_done = 1'b1;
    #2;
    chk("R4", "blocked until edge", int'(win_ready), 0);
    @(negedge clk);
    msq_done  = 1'b0;
    win_valid = 1'b0;
    #2;
    chk("R4", "released", int'(win_ready), 1);
    @(negedge clk);
  endtask

  task automatic t_done_idle();
    @(negedge clk);
    msq_done = 1'b1;
    @(negedge clk);
    msq_done = 1'b0;
    #2;
    chk("R4", "done ignored", int'(win_ready), 1);
    plain_win();
    present();
    chk("R4", "normal after done", int'(consumed), 4);
    idle();
  endtask

  task automatic t_not_valid();
    plain_win();
    @(negedge clk);
    win_valid = 1'b0;
    #2;
    chk("R9", "consumed", int'(consumed), 0);
    chk("R9", "slots", int'(slot_valid), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    win_valid = 1'b0;
    msq_done = 1'b0;
    plain_win();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    t_reset();
    t_all_simple();
    t_complex_head();
    t_complex_late();
    t_fuse_one();
    t_fuse_two_pairs();
    t_hold_last();
    t_pair_multi_partner();
    t_long_late();
    t_long_head();
    t_done_idle();
    t_not_valid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule